// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves bytes over a three-wire synchronous link: a shift clock, a data output and a data input. Transmit and receive always run together on the same shift clock, so every byte sent also captures one byte from the input line. Software works through a small register port with four addresses. Writing the data address queues a byte for sending and starts a transfer. Reading the same address returns the last byte received. A status address reports the buffer and shift flags. A control address and a reload address set up the shift clock.

The shift clock comes from an internal divider, or from a pin when an external master drives it. The internal divider can put a fixed /4 prescaler in front of a reload counter, and a toggle stage follows the counter. A byte queued while the previous one is still shifting goes out back to back, with no idle half-period between them. Two interrupt request lines report transmit progress and received data. The transmit line can be set to fire when the buffer is taken or when the shift has finished.

Top module: `sync_sio`

## Requirements
- R1: Address 0 is shared by both directions. A write stores the transmit byte, and a read returns the receive buffer, which holds the last complete received byte. Address 1 is status: bit0 TBE, bit1 TSC, bit2 RBF, bit3 OVR. Address 2 is control: bit0 selects the external clock, bit1 enables the /4 prescaler, bit2 selects the transmit interrupt source. Address 3 holds the reload value n.
- R2: With the internal clock, each shift-clock half-period lasts exactly (n+1)·P clock cycles, where P is 1, or 4 when the prescaler is on. The full period therefore ranges from 2 to 2048 cycles.
- R3: Each byte produces exactly 8 shift-clock pulses. Data leaves least significant bit first. The output changes on the falling shift-clock edge, the input is sampled on the rising edge, and the clock rests high between transfers.
- R4: Writing address 0 clears TBE. TBE returns to 1 when the byte moves into the transmit shift register.
- R5: TSC drops when a byte is loaded into the shift register. It rises after the last bit is shifted, unless another byte is already waiting.
- R6: `irq_tx` pulses for one cycle when TBE rises (control bit2 = 0) or when TSC rises (control bit2 = 1).
- R7: When a byte completes, the receive buffer is loaded and RBF is set. `irq_rx` pulses for one cycle when RBF goes from 0 to 1. Reading address 0 clears RBF.
- R8: A byte written while TSC is 0 follows the current byte at once, and every shift-clock half-period stays the same length across the byte boundary.
- R9: OVR is set when a byte completes while RBF is still 1. OVR is cleared only by a read of address 0 that comes directly after a status read.
- R10: With the external clock selected, the transfer follows the synchronised `sclk_in` edges: the output changes on its falls and the input is sampled on its rises. `sclk_out` stays high.
- R11: After reset the status reads 0x03, `sclk_out` and `txd` are 1, and both interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for the addressed register |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Internal shift clock, idles high |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| irq_tx | output | 1 | Transmit interrupt request pulse |
| irq_rx | output | 1 | Receive interrupt request pulse |

## Verification
The bench uses the defaults: 8-bit data, an 8-bit reload and a /4 prescaler. With `txd` looped back to `rxd`, every transmitted byte can be compared with the receive buffer. It sweeps reload values 0 to 7 with and without the prescaler, plus the slowest setting of 255 with the prescaler. It measures every half-period against (n+1)·P, and it sends all 256 byte values at the fastest rate. Back-to-back pairs, run under both interrupt sources, exercise gap-free chaining, the interrupt counts and the overrun set/clear sequence. A bench-driven external clock covers the slave mode.

// File: rtl/sync_sio.sv
module sync_sio #(
  parameter int DW = 8,
  parameter int RW = 8,
  parameter int PRE_LOG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          sclk_in,
  output logic          sclk_out,
  output logic          txd,
  input  logic          rxd,
  output logic          irq_tx,
  output logic          irq_rx
);

  localparam int CW = $clog2(DW);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_REL  = 2'd3;

  logic [DW-1:0] tx_buf, tx_sh, rx_sh, rx_buf;
  logic [RW-1:0] reload, baud_cnt;
  logic [PRE_LOG-1:0] pre_cnt;
  logic [2:0] ctrl;
  logic [CW-1:0] bit_cnt;
  logic [2:0] ext_sync;
  logic tbe, tsc, rbf, ovr, busy, sclk_q, txd_q, stat_seen;
  logic tbe_d, tsc_d, rbf_d;

  wire ext_sel = ctrl[0];
  wire pre_sel = ctrl[1];
  wire tic     = ctrl[2];

  wire wr_buf  = reg_wr && reg_addr == A_DATA;
  wire rd_buf  = reg_rd && reg_addr == A_DATA;
  wire rd_stat = reg_rd && reg_addr == A_STAT;
  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire wr_rel  = reg_wr && reg_addr == A_REL;

  wire src_tick  = !pre_sel || (&pre_cnt);
  wire term      = busy && !ext_sel && src_tick && baud_cnt == '0;
  wire ext_fall  = ext_sync[2] && !ext_sync[1];
  wire ext_rise  = !ext_sync[2] && ext_sync[1];
  wire fall_ev   = busy && (ext_sel ? ext_fall : (term && sclk_q));
  wire rise_ev   = busy && (ext_sel ? ext_rise : (term && !sclk_q));
  wire byte_done = rise_ev && bit_cnt == CW'(DW-1);
  wire start     = !busy && !tbe;
  wire chain     = byte_done && !tbe;
  wire load      = start || chain;
  wire [DW-1:0] rx_next = {rxd, rx_sh[DW-1:1]};

  assign sclk_out = sclk_q;
  assign txd      = txd_q;
  assign irq_tx   = tic ? (tsc && !tsc_d) : (tbe && !tbe_d);
  assign irq_rx   = rbf && !rbf_d;

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = rx_buf;
      A_STAT:  reg_rdata = DW'({ovr, rbf, tsc, tbe});
      A_CTRL:  reg_rdata = DW'(ctrl);
      default: reg_rdata = DW'(reload);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sync <= '1;
    else        ext_sync <= {ext_sync[1:0], sclk_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      baud_cnt <= '0;
    end else if (start) begin
      pre_cnt  <= '0;
      baud_cnt <= reload;
    end else if (busy && !ext_sel) begin
      pre_cnt <= pre_cnt + 1'b1;
      if (src_tick) baud_cnt <= (baud_cnt == '0) ? reload : baud_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sclk_q <= 1'b1;
    else if (!busy || ext_sel) sclk_q <= 1'b1;
    else if (term)             sclk_q <= ~sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      txd_q   <= 1'b1;
      bit_cnt <= '0;
    end else begin
      if (fall_ev) begin
        txd_q <= tx_sh[0];
        tx_sh <= tx_sh >> 1;
      end
      if (rise_ev) begin
        rx_sh   <= rx_next;
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (load) begin
        tx_sh   <= tx_buf;
        bit_cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbe <= 1'b1;
      tsc <= 1'b1;
      busy <= 1'b0;
      tx_buf <= '0;
      ctrl <= '0;
      reload <= '0;
    end else begin
      if (wr_ctrl) ctrl <= reg_wdata[2:0];
      if (wr_rel)  reload <= reg_wdata[RW-1:0];
      if (load) begin
        tbe  <= 1'b1;
        tsc  <= 1'b0;
        busy <= 1'b1;
      end else if (byte_done) begin
        tsc  <= 1'b1;
        busy <= 1'b0;
      end
      if (wr_buf) begin
        tx_buf <= reg_wdata;
        tbe    <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbf <= 1'b0;
      ovr <= 1'b0;
      rx_buf <= '0;
      stat_seen <= 1'b0;
    end else begin
      if (reg_rd || reg_wr) stat_seen <= rd_stat;
      if (rd_buf) begin
        rbf <= 1'b0;
        if (stat_seen) ovr <= 1'b0;
      end
      if (byte_done) begin
        rx_buf <= rx_next;
        rbf    <= 1'b1;
        if (rbf && !rd_buf) ovr <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbe_d <= 1'b1;
      tsc_d <= 1'b1;
      rbf_d <= 1'b0;
    end else begin
      tbe_d <= tbe;
      tsc_d <= tsc;
      rbf_d <= rbf;
    end
  end

endmodule

// File: rtl/sync_sio_chk.sv
module sync_sio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_addr,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic       tbe,
  input logic       tsc,
  input logic       rbf,
  input logic       ovr,
  input logic       tic,
  input logic       byte_done,
  input logic       sclk_out,
  input logic       irq_tx,
  input logic       irq_rx
);

  AST_WRITE_EMPTIES_TBE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> !tbe); // R4

  AST_TSC_AFTER_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tsc) |-> $past(byte_done)); // R5

  AST_IDLE_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tsc |-> sclk_out); // R3

  AST_TX_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> (tic ? tsc : tbe)); // R6

  AST_RX_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |=> !irq_rx); // R7

  AST_RX_IRQ_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> rbf); // R7

  AST_READ_DROPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd0 && !byte_done) |=> !rbf); // R7

  AST_OVERRUN_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> rbf); // R9

endmodule

bind sync_sio sync_sio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .tbe(tbe), .tsc(tsc), .rbf(rbf), .ovr(ovr), .tic(tic), .byte_done(byte_done),
  .sclk_out(sclk_out), .irq_tx(irq_tx), .irq_rx(irq_rx)
);

// File: tb/sync_sio_test.sv
`timescale 1ns/1ps
module sync_sio_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0;
  logic reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic sclk_in = 1'b1;
  logic sclk_out, txd, irq_tx, irq_rx;

  always #4 clk = ~clk;

  sync_sio uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_in(sclk_in), .sclk_out(sclk_out),
    .txd(txd), .rxd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  int nchk = 0, nfail = 0;
  int seg = 0, exp_half = 1;
  int cyc = 0, last_edge = 0, mon_seg = 0;
  int edges = 0, gap_bad = 0, txirq_n = 0, rxirq_n = 0;
  logic prev_sclk = 1'b1;
  logic [7:0] cap = 8'd0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n && sclk_out !== prev_sclk) begin
      if (mon_seg == seg && cyc - last_edge != exp_half) gap_bad++;
      mon_seg = seg;
      edges++;
      last_edge = cyc;
      if (sclk_out) cap = {txd, cap[7:1]};
    end
    prev_sclk = sclk_out;
    if (irq_tx) txirq_n++;
    if (irq_rx) rxirq_n++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    repeat (2) @(negedge clk);
    do rd(2'd1, s); while (!(s[0] && s[1]));
  endtask

  task automatic single(input logic [7:0] b, input int n, input bit p);
    int e0, g0;
    logic [7:0] r, s;
    wr(2'd3, 8'(n));
    wr(2'd2, p ? 8'h02 : 8'h00);
    seg++;
    exp_half = (n + 1) * (p ? 4 : 1);
    e0 = edges; g0 = gap_bad;
    wr(2'd0, b);
    wait_idle();
    check(edges - e0 == 16, "R3 edge count", edges - e0, 16);
    check(gap_bad == g0, "R2 half-period", gap_bad - g0, 0);
    check(cap == b, "R3 lsb-first txd", cap, b);
    rd(2'd1, s);
    check(s[2] == 1'b1, "R7 rbf set", s[2], 1);
    rd(2'd0, r);
    check(r == b, "R1 receive buffer", r, b);
    rd(2'd1, s);
    check(s[2] == 1'b0, "R7 rbf cleared by read", s[2], 0);
  endtask

  task automatic pair(input logic [7:0] a, input logic [7:0] b, input bit tic);
    int e0, g0, t0, r0;
    logic [7:0] s, r;
    wr(2'd3, 8'd2);
    wr(2'd2, tic ? 8'h04 : 8'h00);
    seg++;
    exp_half = 3;
    e0 = edges; g0 = gap_bad; t0 = txirq_n; r0 = rxirq_n;
    wr(2'd0, a);
    repeat (2) @(negedge clk);
    do rd(2'd1, s); while (!s[0]);
    check(s[1] == 1'b0, "R5 tsc low while shifting", s[1], 0);
    wr(2'd0, b);
    wait_idle();
    check(edges - e0 == 32, "R8 chained edge count", edges - e0, 32);
    check(gap_bad == g0, "R8 no gap", gap_bad - g0, 0);
    check(cap == b, "R3 second byte bits", cap, b);
    check(txirq_n - t0 == (tic ? 1 : 2), "R6 tx irq count", txirq_n - t0, tic ? 1 : 2);
    check(rxirq_n - r0 == 1, "R7 rx irq count", rxirq_n - r0, 1);
    rd(2'd1, s);
    check(s[3] == 1'b1, "R9 overrun set", s[3], 1);
    wr(2'd3, 8'd2);
    rd(2'd0, r);
    check(r == b, "R1 newest byte kept", r, b);
    rd(2'd1, s);
    check(s[3] == 1'b1 && s[2] == 1'b0, "R9 plain read keeps ovr", s, 8'h0b);
    rd(2'd0, r);
    rd(2'd1, s);
    check(s[3] == 1'b0, "R9 status-then-data clears ovr", s[3], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] s, r, ecap;
    int e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, s);
    check(s == 8'h03, "R11 reset status", s, 8'h03);
    check(sclk_out == 1'b1 && txd == 1'b1, "R11 idle lines", {sclk_out, txd}, 2'b11);
    check(irq_tx == 1'b0 && irq_rx == 1'b0, "R11 irq idle", {irq_tx, irq_rx}, 0);

    for (int p = 0; p < 2; p++)
      for (int n = 0; n < 8; n++)
        single(8'h5a ^ 8'(n * 37 + p * 91), n, p[0]);
    single(8'hc3, 255, 1'b1);

    for (int v = 0; v < 256; v++)
      single(8'(v), 0, 1'b0);

    pair(8'h81, 8'h3c, 1'b0);
    pair(8'h17, 8'he4, 1'b1);

    wr(2'd2, 8'h01);
    seg++;
    e0 = edges;
    ecap = 8'd0;
    wr(2'd0, 8'hb6);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1'b0;
      repeat (8) @(negedge clk);
      sclk_in = 1'b1;
      ecap = {txd, ecap[7:1]};
      repeat (8) @(negedge clk);
    end
    wait_idle();
    check(ecap == 8'hb6, "R10 external clock txd", ecap, 8'hb6);
    rd(2'd0, r);
    check(r == 8'hb6, "R10 external clock receive", r, 8'hb6);
    check(edges == e0, "R10 sclk_out quiet", edges - e0, 0);
    wr(2'd2, 8'h00);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule